// File: doc/BRIEF.md
# Read-Triggered Touch ADC Controller

This block sits between a small register bus and the digital output of a multi-input touch-screen converter front end. Software picks which of eight analog inputs feeds the converter by writing a configuration code into a guarded switch register. The switch register accepts a write only if the write comes straight after an unlock key. Software then collects samples by reading the result register. Each read of that register returns whatever is held and also starts a fresh conversion. Software polls with further reads until the ready flag in bit 31 is set.

The controller does the timing that would otherwise be left to software. After every switch change it runs a settling interval, and every conversion takes a fixed number of clock cycles. Both lengths depend on a rate bit in a control register: slow (divide-by-16) or fast (divide-by-4). The converter is modelled as one packed bus that carries a 16-bit two's-complement sample for each of the eight inputs. The controller picks the lane that the switch code selects. Bus accesses take a single cycle and are never stalled. No data path has a valid/ready handshake, because samples are only taken when the internal timer expires and the bus itself has no back-pressure.

Top module: `adc_trigger_ctrl`

## Requirements
- R1: After reset the ready flag is 0, the switch register reads 0, the control register reads 0 (slow rate) and the switch register is locked.
- R2: A write of exactly 0x000000AA to offset 0x20, followed with no other access in between by a write to offset 0x18, stores bits 11:0 of the write data in the switch register. The stored value reads back at 0x18 in bits 11:0, with all higher bits 0.
- R3: A switch write with no key directly before it is ignored. This covers a key followed first by some other read or write, and a wrong key value such as 0x55.
- R4: A read at offset 0x08 starts a conversion. The ready flag (bit 31 of that register, also on `data_rdy`) reads 0 from the next cycle on, until the conversion finishes.
- R5: A finished result reads as bit 31 = 1, bits 15:0 = the selected 16-bit sample, and bits 30:16 each equal to bit 15.
- R6: Bit 0 of the control register at 0x04 selects the rate: 0 = slow, 1 = fast. If the settling interval has expired, `data_rdy` rises exactly CONV_SLOW or CONV_FAST clock edges after the edge that takes the read. The rate in force at the read decides which.
- R7: Conversion counting is held while the settling counter runs. An accepted switch write loads SETTLE_SLOW or SETTLE_FAST, chosen by the rate in force at that write. If the result read comes in the cycle right after the switch write, `data_rdy` rises SETTLE + CONV − 1 edges after the read edge.
- R8: A result read while a conversion is still pending returns bit 31 = 0 and restarts the timer. `data_rdy` then rises CONV edges after the latest read, not after the first one.
- R9: The codes 0x608, 0x680, 0x640, 0x620, 0x610, 0x601, 0x602 and 0x604 select inputs 0 to 7 in that order. Input k is bits 16k+15:16k of `sample_bus`.
- R10: A switch code outside that set is still stored and read back unchanged, but input 0 is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high, else 0 |
| sample_bus | input | 128 | Eight packed signed 16-bit converter samples |
| data_rdy | output | 1 | Ready flag of the held result |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume each access lasts exactly one cycle, so every high strobe counts as a separate access for the lock logic and for starting conversions. The bench drives each strobe for one cycle from a task that releases it at the next falling edge, and it never overlaps a read with a write. The sample lanes are held steady while a conversion runs. This keeps the captured value independent of which edge ends the conversion.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SW_W   = 12;
  localparam int SAMP_W = 16;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SWITCH = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'h20;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] idx;
  } chan_sel_t;

  // configuration code that routes input ch to the converter
  function automatic logic [SW_W-1:0] route_code(input int ch);
    case (ch)
      0:       return 12'h608;
      1:       return 12'h680;
      2:       return 12'h640;
      3:       return 12'h620;
      4:       return 12'h610;
      5:       return 12'h601;
      6:       return 12'h602;
      default: return 12'h604;
    endcase
  endfunction

  function automatic chan_sel_t decode_route(input logic [SW_W-1:0] code);
    chan_sel_t r;
    r = '0;
    for (int i = 0; i < NCH; i++) begin
      if (code == route_code(i)) begin
        r.hit = 1'b1;
        r.idx = CH_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/adc_key_gate.sv
module adc_key_gate
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked,
  output logic              sw_we
);
  logic key_hit;

  assign key_hit = wr && (addr == OFS_LOCK) && (wdata == UNLOCK_KEY);
  assign sw_we   = wr && (addr == OFS_SWITCH) && unlocked;

  // every access decides the next lock state; idle cycles keep it
  always_ff @(posedge clk) begin
    if (!rst_n)
      unlocked <= 1'b0;
    else if (wr || rd)
      unlocked <= key_hit;
  end
endmodule

// File: rtl/adc_switch_reg.sv
module adc_switch_reg
  import adc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SW_W-1:0] wcode,
  output logic [SW_W-1:0] code,
  output logic [CH_W-1:0] chan
);
  chan_sel_t sel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      code <= '0;
    else if (we)
      code <= wcode;
  end

  always_comb begin
    sel  = decode_route(code);
    chan = sel.hit ? sel.idx : '0;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int SETTLE_SLOW = 48,
  parameter int SETTLE_FAST = 12,
  parameter int CONV_SLOW   = 40,
  parameter int CONV_FAST   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic sw_change,
  input  logic start,
  output logic settle_idle,
  output logic conv_pend,
  output logic done
);
  localparam int SMAX  = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int CMAX  = (CONV_SLOW > CONV_FAST) ? CONV_SLOW : CONV_FAST;
  localparam int SET_W = $clog2(SMAX + 1);
  localparam int CNV_W = $clog2(CMAX + 1);

  logic [SET_W-1:0] settle_cnt;
  logic [CNV_W-1:0] conv_cnt;
  logic [SET_W-1:0] settle_load;
  logic [CNV_W-1:0] conv_load;

  assign settle_load = fast ? SET_W'(SETTLE_FAST) : SET_W'(SETTLE_SLOW);
  assign conv_load   = fast ? CNV_W'(CONV_FAST) : CNV_W'(CONV_SLOW);
  assign settle_idle = (settle_cnt == '0);
  assign done        = conv_pend && settle_idle && !start && (conv_cnt <= CNV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      settle_cnt <= '0;
    else if (sw_change)
      settle_cnt <= settle_load;
    else if (!settle_idle)
      settle_cnt <= settle_cnt - SET_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_pend <= 1'b0;
      conv_cnt  <= '0;
    end else if (start) begin
      conv_pend <= 1'b1;
      conv_cnt  <= conv_load;
    end else if (done) begin
      conv_pend <= 1'b0;
      conv_cnt  <= '0;
    end else if (conv_pend && settle_idle) begin
      conv_cnt  <= conv_cnt - CNV_W'(1);
    end
  end
endmodule

// File: rtl/adc_trigger_ctrl.sv
module adc_trigger_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int SETTLE_SLOW = 48,
  parameter int SETTLE_FAST = 12,
  parameter int CONV_SLOW   = 40,
  parameter int CONV_FAST   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NCH*SAMP_W-1:0]   sample_bus,
  output logic                    data_rdy
);
  localparam int EXT_W = DATA_W - 1 - SAMP_W;

  logic              unlocked;
  logic              sw_we;
  logic [SW_W-1:0]   sw_code;
  logic [CH_W-1:0]   sw_chan;
  logic              rate_fast;
  logic              settle_idle;
  logic              conv_pend;
  logic              conv_done;
  logic              conv_start;
  logic [SAMP_W-1:0] result_q;
  logic [SAMP_W-1:0] lane;

  assign conv_start = bus_rd && (bus_addr == OFS_RESULT);

  adc_key_gate u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .unlocked (unlocked),
    .sw_we    (sw_we)
  );

  adc_switch_reg u_sw (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sw_we),
    .wcode (bus_wdata[SW_W-1:0]),
    .code  (sw_code),
    .chan  (sw_chan)
  );

  adc_conv_timer #(
    .SETTLE_SLOW (SETTLE_SLOW),
    .SETTLE_FAST (SETTLE_FAST),
    .CONV_SLOW   (CONV_SLOW),
    .CONV_FAST   (CONV_FAST)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast        (rate_fast),
    .sw_change   (sw_we),
    .start       (conv_start),
    .settle_idle (settle_idle),
    .conv_pend   (conv_pend),
    .done        (conv_done)
  );

  // rate select register
  always_ff @(posedge clk) begin
    if (!rst_n)
      rate_fast <= 1'b0;
    else if (bus_wr && (bus_addr == OFS_CTRL))
      rate_fast <= bus_wdata[0];
  end

  // lane picked by the decoded switch code
  assign lane = sample_bus[sw_chan*SAMP_W +: SAMP_W];

  // held result and its ready flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_rdy <= 1'b0;
      result_q <= '0;
    end else if (conv_start) begin
      data_rdy <= 1'b0;
    end else if (conv_done) begin
      data_rdy <= 1'b1;
      result_q <= lane;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_RESULT: bus_rdata = {data_rdy, {EXT_W{result_q[SAMP_W-1]}}, result_q};
        OFS_SWITCH: bus_rdata = {{(DATA_W-SW_W){1'b0}}, sw_code};
        OFS_CTRL:   bus_rdata = {{(DATA_W-1){1'b0}}, rate_fast};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_trigger_ctrl_chk.sv
module adc_trigger_ctrl_chk
  import adc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              data_rdy,
  input logic              unlocked,
  input logic [SW_W-1:0]   sw_code,
  input logic              settle_idle,
  input logic              conv_pend
);
  a_r2_keyed_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SWITCH && unlocked) |=> (sw_code == $past(bus_wdata[SW_W-1:0])));

  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SWITCH && !unlocked) |=> $stable(sw_code));

  a_r3_access_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || (bus_wr && bus_addr != OFS_LOCK)) |=> !unlocked);

  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RESULT) |=> (!data_rdy && conv_pend));

  a_r5_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RESULT) |-> (bus_rdata[30:16] == {15{bus_rdata[15]}}));

  a_r7_ready_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> $past(settle_idle));

  a_r8_ready_only_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> ($past(conv_pend) && !conv_pend));
endmodule

bind adc_trigger_ctrl adc_trigger_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .data_rdy    (data_rdy),
  .unlocked    (unlocked),
  .sw_code     (sw_code),
  .settle_idle (settle_idle),
  .conv_pend   (conv_pend)
);

// File: tb/sim_adc_trigger_ctrl.sv
module sim_adc_trigger_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SS = 48;
  localparam int SF = 12;
  localparam int CS = 40;
  localparam int CF = 10;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_RES  = 8'h08;
  localparam logic [7:0] A_SW   = 8'h18;
  localparam logic [7:0] A_LOCK = 8'h20;

  // {switch code, expected input}
  localparam logic [15:0] VEC [0:9] = '{
    {12'h608, 4'd0}, {12'h680, 4'd1}, {12'h640, 4'd2}, {12'h620, 4'd3},
    {12'h610, 4'd4}, {12'h601, 4'd5}, {12'h602, 4'd6}, {12'h604, 4'd7},
    {12'h6FF, 4'd0}, {12'h001, 4'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] sample_bus = '0;
  logic         data_rdy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trigger_ctrl #(.SETTLE_SLOW(SS), .SETTLE_FAST(SF), .CONV_SLOW(CS), .CONV_FAST(CF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_bus(sample_bus), .data_rdy(data_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // cycles from the current falling edge until data_rdy is seen
  task automatic wait_rdy(output int lat);
    lat = 0;
    while (!data_rdy && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [15:0] lane_val(input int v, input int k);
    return 16'(k * 5003 - 21000 + v * 97);
  endfunction

  task automatic load_lanes(input int v);
    for (int k = 0; k < 8; k++) sample_bus[k*16 +: 16] = lane_val(v, k);
  endtask

  function automatic logic [31:0] fmt(input logic [15:0] s);
    return {1'b1, {15{s[15]}}, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'b0, data_rdy}, 32'd0);
    brd(A_SW, d);   chk("R1 switch", d, 32'd0);
    brd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
    brd(A_RES, d);  chk("R1 result", d, 32'd0);
    bwr(A_SW, 32'h608);
    brd(A_SW, d);   chk("R1 locked", d, 32'd0);

    // table walk: R2, R9, R10, R5
    for (int v = 0; v < 10; v++) begin
      load_lanes(v);
      bwr(A_LOCK, 32'hAA);
      bwr(A_SW, {20'hFFFFF, VEC[v][15:4]});
      brd(A_SW, d);
      chk(v >= 8 ? "R10 stored" : "R2 stored", d, {20'b0, VEC[v][15:4]});
      brd(A_RES, d);
      wait_rdy(lat);
      brd(A_RES, d);
      chk(v >= 8 ? "R10 input0" : "R9 R5 sample", d, fmt(lane_val(v, int'(VEC[v][3:0]))));
      wait_rdy(lat);
    end

    // R3 wrong key, key then other read, key then other write
    bwr(A_LOCK, 32'h55); bwr(A_SW, 32'h680);
    brd(A_SW, d); chk("R3 wrong key", d, 32'h001);
    bwr(A_LOCK, 32'hAA); brd(A_CTRL, d); bwr(A_SW, 32'h680);
    brd(A_SW, d); chk("R3 read relocks", d, 32'h001);
    bwr(A_LOCK, 32'hAA); bwr(A_CTRL, 32'h0); bwr(A_SW, 32'h680);
    brd(A_SW, d); chk("R3 write relocks", d, 32'h001);

    // settle back to idle, then R4 and R6 slow latency
    repeat (SS + 2) @(negedge clk);
    brd(A_RES, d);
    chk("R4 cleared", {31'b0, data_rdy}, 32'd0);
    wait_rdy(lat);
    chk("R6 slow latency", lat, CS);

    // R6 fast
    bwr(A_CTRL, 32'h1);
    brd(A_CTRL, d); chk("R6 ctrl readback", d, 32'h1);
    brd(A_RES, d);
    wait_rdy(lat);
    chk("R6 fast latency", lat, CF);

    // R7 fast settle
    bwr(A_LOCK, 32'hAA); bwr(A_SW, 32'h604);
    brd(A_RES, d);
    wait_rdy(lat);
    chk("R7 fast settle", lat, SF + CF - 1);

    // R7 slow settle
    bwr(A_CTRL, 32'h0);
    bwr(A_LOCK, 32'hAA); bwr(A_SW, 32'h620);
    brd(A_RES, d);
    wait_rdy(lat);
    chk("R7 slow settle", lat, SS + CS - 1);

    // R8 restart while pending
    load_lanes(3);
    brd(A_RES, d);
    repeat (5) @(negedge clk);
    brd(A_RES, d);
    chk("R8 pending flag", {31'b0, d[31]}, 32'd0);
    wait_rdy(lat);
    chk("R8 restart latency", lat, CS);
    brd(A_RES, d);
    chk("R8 sample", d, fmt(lane_val(3, 3)));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule